// File: doc/BRIEF.md
# Segmented Ternary Content-Addressable Memory

This block holds a small table of ternary entries. Each entry is a data word, a per-bit care mask and a valid flag. A cleared care bit turns that bit into a don't-care that matches either key value. A search key presented with a valid strobe is compared against every entry at once. The block reports whether any entry matched and the index of the lowest-numbered matching entry. A new key can be issued on every cycle.

To cut switching activity, the search is split into two pipeline stages. In the first cycle only a short lead slice at the top of the word is compared. In the second cycle the wide remaining slice is compared, and only for entries whose lead slice matched. Every other entry has its tail comparator held idle and is marked as a miss. The result also carries the number of tail comparators that were enabled for that search, which shows how much work the split saved. Entries are loaded through a single-entry write port.

Top module: `tcam_seg_search`

## Requirements
- R1: A key bit whose care bit is 1 must equal the stored bit. A key bit whose care bit is 0 matches both 0 and 1. An entry hits only when all of its cared bits agree with the key.
- R2: When several entries hit, `res_idx_o` gives the lowest-numbered of them.
- R3: The asynchronous reset `rst_ni` marks every entry invalid and empties the pipeline. Invalid entries never hit and are never counted.
- R4: `res_valid_o` is high exactly two clock edges after an edge at which `srch_valid_i` was sampled high. It is never high otherwise. Keys issued on consecutive cycles each produce their own result.
- R5: `res_en_cnt_o` equals the number of valid entries whose cared lead bits match the key. The lead bits are bits [KEY_W-1 : KEY_W-LEAD_W].
- R6: An entry that misses on the lead slice never hits, even when its tail slice matches. An entry that matches the lead slice but misses the tail is counted but does not hit.
- R7: A write at one clock edge is visible to a search sampled at the next edge.
- R8: While `res_valid_o` is low, `res_hit_o`, `res_idx_o` and `res_en_cnt_o` are all zero. On a miss, `res_idx_o` is zero.
- R9: When every entry is valid with an all-zero care mask, a search hits entry 0 and reports a count equal to NUM_ENTRIES.
- R10: A write with `wr_valid_i` low removes that entry from later searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one entry |
| wr_addr_i | input | IDX_W | Entry to write |
| wr_data_i | input | KEY_W | Stored data word |
| wr_care_i | input | KEY_W | Care mask (1 = compare, 0 = don't-care) |
| wr_valid_i | input | 1 | Valid flag written with the entry |
| srch_valid_i | input | 1 | Search strobe |
| srch_key_i | input | KEY_W | Search key |
| res_valid_o | output | 1 | Result strobe, two cycles after the search |
| res_hit_o | output | 1 | At least one entry matched |
| res_idx_o | output | IDX_W | Lowest matching entry index |
| res_en_cnt_o | output | CNT_W | Tail comparators enabled for this search |

## Verification
The case that is hardest to reach from the ports is an entry that agrees on its tail but not on its lead slice. A plain linear scan would report it as a near-miss, while the split search must neither count it nor let it hit. Directed writes build entries that differ from a reference word only in the top bit. The bench then searches with both variants, so that lead-only and tail-only agreement each occur. A random phase issues back-to-back keys taken from stored words, some with a single bit flipped, against sparse care masks. This makes multiple hits, don't-care hits and counted tail misses frequent. It also interleaves writes so that the next-cycle visibility rule is exercised.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_KEY_W   = 144;
  localparam int unsigned DEF_LEAD_W  = 3;
endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
  parameter int unsigned N  = 16,
  parameter int unsigned KW = 144,
  parameter int unsigned AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [KW-1:0]         wr_data_i,
  input  logic [KW-1:0]         wr_care_i,
  input  logic                  wr_valid_i,
  output logic [N-1:0][KW-1:0]  data_o,
  output logic [N-1:0][KW-1:0]  care_o,
  output logic [N-1:0]          valid_o
);
  for (genvar e = 0; e < N; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == AW'(e));

    // data/care need no reset: valid gates them (R3)
    always_ff @(posedge clk_i) begin
      if (sel) begin
        data_o[e] <= wr_data_i;
        care_o[e] <= wr_care_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_o[e] <= 1'b0;
      else if (sel) valid_o[e] <= wr_valid_i;  // R10
    end
  end
endmodule

// File: rtl/tcam_lead_cmp.sv
module tcam_lead_cmp #(
  parameter int unsigned N  = 16,
  parameter int unsigned KW = 144,
  parameter int unsigned LW = 3
) (
  input  logic [LW-1:0]         key_lead_i,
  input  logic [N-1:0][KW-1:0]  data_i,
  input  logic [N-1:0][KW-1:0]  care_i,
  input  logic [N-1:0]          valid_i,
  output logic [N-1:0]          match_o
);
  for (genvar e = 0; e < N; e++) begin : g_cmp
    logic [LW-1:0] diff;
    assign diff       = (key_lead_i ^ data_i[e][KW-1 -: LW]) & care_i[e][KW-1 -: LW];
    assign match_o[e] = valid_i[e] && (diff == '0);  // R1, R3
  end
endmodule

// File: rtl/tcam_tail_cmp.sv
module tcam_tail_cmp #(
  parameter int unsigned N  = 16,
  parameter int unsigned TW = 141
) (
  input  logic [N-1:0]          en_i,
  input  logic [TW-1:0]         key_tail_i,
  input  logic [N-1:0][TW-1:0]  data_i,
  input  logic [N-1:0][TW-1:0]  care_i,
  output logic [N-1:0]          hit_o
);
  for (genvar e = 0; e < N; e++) begin : g_cmp
    logic [TW-1:0] key_iso;
    logic [TW-1:0] diff;
    // operand isolation: a disabled comparator sees a static key
    assign key_iso  = en_i[e] ? key_tail_i : '0;
    assign diff     = (key_iso ^ data_i[e]) & care_i[e];
    assign hit_o[e] = en_i[e] && (diff == '0);  // R6
  end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);  // lowest wins (R2)
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tcam_seg_search.sv
module tcam_seg_search
  import tcam_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = DEF_ENTRIES,
  parameter int unsigned KEY_W       = DEF_KEY_W,
  parameter int unsigned LEAD_W      = DEF_LEAD_W,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic [KEY_W-1:0] wr_care_i,
  input  logic             wr_valid_i,
  input  logic             srch_valid_i,
  input  logic [KEY_W-1:0] srch_key_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [CNT_W-1:0] res_en_cnt_o
);
  localparam int unsigned TAIL_W = KEY_W - LEAD_W;

  logic [NUM_ENTRIES-1:0][KEY_W-1:0]  ent_data;
  logic [NUM_ENTRIES-1:0][KEY_W-1:0]  ent_care;
  logic [NUM_ENTRIES-1:0]             ent_valid;
  logic [NUM_ENTRIES-1:0][TAIL_W-1:0] tail_data;
  logic [NUM_ENTRIES-1:0][TAIL_W-1:0] tail_care;

  logic [NUM_ENTRIES-1:0] lead_match;
  logic                   s1_valid_q;
  logic [NUM_ENTRIES-1:0] s1_en_q;
  logic [TAIL_W-1:0]      s1_tail_q;
  logic [NUM_ENTRIES-1:0] tail_hit;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;
  logic [CNT_W-1:0]       en_cnt;

  tcam_entry_store #(.N(NUM_ENTRIES), .KW(KEY_W), .AW(IDX_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wr_care_i  (wr_care_i),
    .wr_valid_i (wr_valid_i),
    .data_o     (ent_data),
    .care_o     (ent_care),
    .valid_o    (ent_valid)
  );

  // stage 1: lead slice against current table (R7)
  tcam_lead_cmp #(.N(NUM_ENTRIES), .KW(KEY_W), .LW(LEAD_W)) i_lead (
    .key_lead_i (srch_key_i[KEY_W-1 -: LEAD_W]),
    .data_i     (ent_data),
    .care_i     (ent_care),
    .valid_i    (ent_valid),
    .match_o    (lead_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_en_q    <= '0;
    end else begin
      s1_valid_q <= srch_valid_i;
      s1_en_q    <= srch_valid_i ? lead_match : '0;
    end
  end

  // tail key only loads on a search, keeps idle cycles quiet
  always_ff @(posedge clk_i) begin
    if (srch_valid_i) s1_tail_q <= srch_key_i[TAIL_W-1:0];
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_tail
    assign tail_data[e] = ent_data[e][TAIL_W-1:0];
    assign tail_care[e] = ent_care[e][TAIL_W-1:0];
  end

  // stage 2: wide compare only where stage 1 matched
  tcam_tail_cmp #(.N(NUM_ENTRIES), .TW(TAIL_W)) i_tail (
    .en_i       (s1_en_q),
    .key_tail_i (s1_tail_q),
    .data_i     (tail_data),
    .care_i     (tail_care),
    .hit_o      (tail_hit)
  );

  tcam_prio_enc #(.N(NUM_ENTRIES), .IW(IDX_W)) i_prio (
    .req_i (tail_hit),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_comb begin
    en_cnt = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      en_cnt = en_cnt + CNT_W'(s1_en_q[i]);  // R5
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_idx_o    <= '0;
      res_en_cnt_o <= '0;
    end else begin
      res_valid_o  <= s1_valid_q;  // R4
      res_hit_o    <= s1_valid_q && any_hit;
      res_idx_o    <= (s1_valid_q && any_hit) ? win_idx : '0;  // R8
      res_en_cnt_o <= s1_valid_q ? en_cnt : '0;
    end
  end
endmodule

// File: rtl/tcam_seg_search_chk.sv
module tcam_seg_search_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srch_valid_i,
  input logic          res_valid_o,
  input logic          res_hit_o,
  input logic [IW-1:0] res_idx_o,
  input logic [CW-1:0] res_en_cnt_o
);
  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_valid_i |=> ##1 res_valid_o)
    else $error("R4 result missing two cycles after search");

  p_no_spurious_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_valid_i |=> ##1 !res_valid_o)
    else $error("R4 result without search");

  p_idle_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_hit_o && res_idx_o == '0 && res_en_cnt_o == '0))
    else $error("R8 outputs not cleared while idle");

  p_miss_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> res_idx_o == '0)
    else $error("R8 index nonzero on miss");

  p_hit_needs_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_en_cnt_o != '0)
    else $error("R6 hit with no tail compare enabled");

  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> (32'(res_idx_o) < N))
    else $error("R2 index out of range");

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(res_en_cnt_o) <= N)
    else $error("R9 count above entry number");
endmodule

bind tcam_seg_search tcam_seg_search_chk #(
  .N (NUM_ENTRIES),
  .IW(IDX_W),
  .CW(CNT_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srch_valid_i (srch_valid_i),
  .res_valid_o  (res_valid_o),
  .res_hit_o    (res_hit_o),
  .res_idx_o    (res_idx_o),
  .res_en_cnt_o (res_en_cnt_o)
);

// File: tb/test_tcam_seg_search.sv
`timescale 1ns/1ps
module test_tcam_seg_search;
  import tcam_pkg::*;
  localparam int N  = DEF_ENTRIES;
  localparam int KW = DEF_KEY_W;
  localparam int LW = DEF_LEAD_W;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam int CLK_PERIOD = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [IW-1:0] wr_addr_i = '0;
  logic [KW-1:0] wr_data_i = '0;
  logic [KW-1:0] wr_care_i = '0;
  logic          wr_valid_i = 1'b0;
  logic          srch_valid_i = 1'b0;
  logic [KW-1:0] srch_key_i = '0;
  logic          res_valid_o;
  logic          res_hit_o;
  logic [IW-1:0] res_idx_o;
  logic [CW-1:0] res_en_cnt_o;

  tcam_seg_search i_tcam_seg_search (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    bit    hit;
    int    idx;
    int    cnt;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e_mon;
  logic [KW-1:0] m_data [N];
  logic [KW-1:0] m_care [N];
  bit            m_valid[N];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] rnd();
    logic [KW-1:0] r;
    for (int i = 0; i < KW; i++) r[i] = 1'($urandom_range(1, 0));
    return r;
  endfunction

  // linear scan over the full key
  function automatic exp_t model(logic [KW-1:0] k, string tag);
    exp_t x;
    x.hit = 0; x.idx = 0; x.cnt = 0; x.cyc = cyc; x.tag = tag;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i]) begin
        if ((((k ^ m_data[i]) & m_care[i]) >> (KW - LW)) == '0) x.cnt++;
        if (((k ^ m_data[i]) & m_care[i]) == '0 && !x.hit) begin
          x.hit = 1; x.idx = i;
        end
      end
    end
    return x;
  endfunction

  task automatic wr(int a, logic [KW-1:0] d, logic [KW-1:0] c, bit v);
    @(negedge clk_i);
    srch_valid_i = 0;
    wr_en_i = 1; wr_addr_i = IW'(a); wr_data_i = d; wr_care_i = c; wr_valid_i = v;
    @(posedge clk_i);
    m_data[a] = d; m_care[a] = c; m_valid[a] = v;
  endtask

  task automatic srch(logic [KW-1:0] k, string tag);
    @(negedge clk_i);
    wr_en_i = 0;
    srch_valid_i = 1; srch_key_i = k;
    q.push_back(model(k, tag));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk_i);
      wr_en_i = 0; srch_valid_i = 0;
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (res_valid_o) begin
        if (q.size() == 0) chk(0, "R4", "unexpected result", 1, 0);
        else begin
          e_mon = q.pop_front();
          chk(cyc == e_mon.cyc + 2, "R4", "latency", cyc - e_mon.cyc, 2);
          chk(res_hit_o == e_mon.hit, e_mon.tag, "hit", int'(res_hit_o), int'(e_mon.hit));
          chk(int'(res_idx_o) == e_mon.idx, e_mon.tag, "idx", int'(res_idx_o), e_mon.idx);
          chk(int'(res_en_cnt_o) == e_mon.cnt, e_mon.tag, "en_cnt", int'(res_en_cnt_o), e_mon.cnt);
        end
      end else begin
        chk(!res_hit_o && res_idx_o == '0 && res_en_cnt_o == '0, "R8", "idle outputs",
            int'(res_hit_o) + int'(res_idx_o) + int'(res_en_cnt_o), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "watchdog", "timeout", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [KW-1:0] d, all1, top;
    all1 = '1;
    top  = {1'b1, {(KW-1){1'b0}}};
    d    = rnd();
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_data[i] = '0; m_care[i] = '0; end

    // reset state: R3, R8
    @(negedge clk_i);
    chk(!res_valid_o && !res_hit_o && res_en_cnt_o == '0, "R3", "outputs in reset",
        int'(res_valid_o) + int'(res_hit_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    idle(2);
    srch(d, "R3");                      // empty table -> miss, count 0

    wr(5, d, all1, 1);
    srch(d, "R7");                      // next cycle sees entry 5
    srch(d ^ KW'(1), "R6");             // tail miss, lead counted
    wr(2, d, all1 << (KW/2), 1);        // low half don't-care
    srch(d, "R2");                      // 2 and 5 hit -> 2
    srch(d ^ KW'(1), "R1");             // don't-care bit -> 2 only
    wr(9, d ^ top, all1, 1);
    srch(d, "R6");                      // 9 lead miss: not counted
    srch(d ^ top, "R5");                // only 9 in lead and hit
    wr(2, d, all1 << (KW/2), 0);
    srch(d, "R10");                     // entry 2 gone -> 5
    srch(d ^ KW'(2), "R4");             // back-to-back
    srch(d, "R4");
    idle(3);

    for (int i = 0; i < N; i++) wr(i, rnd(), '0, 1);
    srch(rnd(), "R9");
    srch(d, "R9");
    idle(3);

    // random phase
    for (int i = 0; i < N; i++) wr(i, rnd(), rnd() & rnd(), ($urandom_range(3, 0) != 0));
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(7, 0) == 0) begin
        wr($urandom_range(N-1, 0), rnd(), rnd() & rnd() & rnd(), ($urandom_range(4, 0) != 0));
      end else begin
        logic [KW-1:0] k;
        k = m_data[$urandom_range(N-1, 0)];
        if ($urandom_range(1, 0) == 1) k[$urandom_range(KW-1, 0)] ^= 1'b1;
        srch(k, "R1");
      end
    end
    idle(4);

    // asynchronous reset clears table: R3
    @(negedge clk_i);
    rst_ni = 0;
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    #1;
    chk(!res_valid_o && !res_hit_o && res_en_cnt_o == '0, "R3", "outputs after reset",
        int'(res_valid_o) + int'(res_hit_o) + int'(res_en_cnt_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    srch(m_data[0], "R3");
    idle(4);

    chk(q.size() == 0, "R4", "results outstanding", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule